// File: doc/BRIEF.md
# IR receive frame FIFO

This block sits between a fast-IR receive symbol decoder and the host. Decoded bytes are stored in a byte FIFO. Each stored entry carries a frame-boundary tag, so several received frames can wait in the FIFO at once and the host can still tell where each one stops. A status byte shows whether data is waiting, whether the byte at the head closes its frame, and which errors were seen: overrun, frame too long, illegal symbol and bad CRC.

The host loads a 16-bit frame-length limit in two byte writes. A frame that runs past the limit is cut short and its remaining bytes are discarded. An illegal-symbol report aborts the frame at once. In both cases the newest byte already written from that frame is tagged as the frame's end. The error and overrun flags stay set until the host reads the status byte. The data-ready and last-byte flags always follow the FIFO contents.

Top module: `irrx_frame_fifo`

## Requirements
- R1: After reset the FIFO is empty, every status bit is 0 and the length limit is 2048. Status bits 6 and 5 always read 0.
- R2: Stored bytes leave in arrival order. `rd_data` shows the head byte. Status bit 0 (data-ready) is 1 exactly when the FIFO holds at least one entry, and a `host_rd` pulse removes the head entry.
- R3: Status bit 7 is 1 when the FIFO is not empty and the head entry is the last byte of its frame. A `frame_end` pulse tags the newest byte of the frame. If a byte arrives in the same cycle as `frame_end`, that byte is stored already tagged.
- R4: The limit is loaded through `lim_lo_we` (bits 7:0) and `lim_hi_we` (bits 15:8) and applies from the next cycle. When a byte would bring the frame's count above the limit, status bit 4 is set, the byte is dropped, the newest stored byte of the frame is tagged, and further bytes are dropped until `frame_end` or `sym_err`.
- R5: A `sym_err` pulse sets status bit 4's neighbour, bit 3. It tags the newest stored byte of the frame and resets the frame byte count. In that cycle it takes priority over `rx_valid` and `frame_end`, which are both ignored.
- R6: A `frame_end` pulse with `crc_ok` low sets status bit 2. On every `frame_end` the byte count is reset and any length cut is lifted.
- R7: A byte that arrives within the limit while the FIFO holds DEPTH (32) entries is dropped and sets status bit 1. It still counts toward the frame length.
- R8: A `stat_rd` pulse clears status bits 4 to 1. A flag that is set in the same cycle as the read stays set.
- R9: A `host_rd` pulse while the FIFO is empty has no effect.
- R10: A `frame_end` or `sym_err` for a frame that stored no byte adds no entry and leaves data-ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lim_lo_we | input | 1 | Load `lim_wdata` into limit bits 7:0 |
| lim_hi_we | input | 1 | Load `lim_wdata` into limit bits 15:8 |
| lim_wdata | input | 8 | Limit byte to load |
| rx_valid | input | 1 | Decoded byte strobe |
| rx_byte | input | 8 | Decoded byte |
| sym_err | input | 1 | Illegal-symbol strobe |
| frame_end | input | 1 | End-of-frame strobe |
| crc_ok | input | 1 | CRC good, sampled with `frame_end` |
| host_rd | input | 1 | Pop the head entry |
| stat_rd | input | 1 | Status read, clears sticky flags |
| rd_data | output | 8 | Head byte |
| status | output | 8 | Status byte |

## Verification
The bench targets these corner cases:
- A byte and `frame_end` in the same cycle. A design that handled this wrongly would leave the frame untagged, or would tag the byte before it.
- A frame cut by the limit. A wrong design would keep storing bytes past the limit, or would fail to tag the byte at the cut.
- `sym_err` in the same cycle as a byte. A wrong design would store that byte.
- A byte arriving into a full FIFO. This must set overrun without losing queued data.
- `stat_rd` in the same cycle as a new error. A design that let the clear win would lose that error.
- Reads of an empty FIFO, frames that stored nothing, and limit changes during a random traffic phase. A wrong design would show stray entries or pointer slips, which appear as out-of-order bytes.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ST_DRDY = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_CRC  = 2;
    localparam int ST_PHY  = 3;
    localparam int ST_LEN  = 4;
    localparam int ST_LAST = 7;

    typedef struct packed {
        logic len;
        logic phy;
        logic crc;
        logic ovr;
    } rx_flags_t;
endpackage

// File: rtl/irrx_limit_reg.sv
module irrx_limit_reg #(
    parameter int          LEN_W   = 16,
    parameter logic [15:0] LIM_RST = 16'd2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [7:0]       wdata,
    output logic [LEN_W-1:0] limit
);
    logic [LEN_W-1:0] lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (lo_we) lim_d[7:0] = wdata;
        if (hi_we) lim_d[LEN_W-1:8] = wdata[LEN_W-9:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lim_q <= LIM_RST[LEN_W-1:0];
        else        lim_q <= lim_d;
    end

    assign limit = lim_q;

    // R4: the limit changes only when loaded
    a_r4_limit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_we && !hi_we) |=> $stable(lim_q));
endmodule

// File: rtl/irrx_entry_fifo.sv
module irrx_entry_fifo
    import irrx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  rx_entry_t wr_entry,
    input  logic      rd_en,
    input  logic      retag_en,
    output rx_entry_t head,
    output logic      nonempty,
    output logic      full
);
    localparam logic [PTR_W:0] FULL_CNT = DEPTH[PTR_W:0];

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W:0]   count;
    } fifo_st_t;

    fifo_st_t  st_d, st_q;
    rx_entry_t mem [DEPTH];
    logic      do_rd;
    logic [PTR_W-1:0] last_ptr;

    assign do_rd    = rd_en && (st_q.count != '0);
    assign last_ptr = st_q.wr_ptr - 1'b1;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (do_rd) st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        case ({wr_en, do_rd})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[st_q.wr_ptr] <= wr_entry;
        else if (retag_en && st_q.count != '0)
            mem[last_ptr].eof <= 1'b1;
    end

    assign head     = mem[st_q.rd_ptr];
    assign nonempty = (st_q.count != '0);
    assign full     = (st_q.count == FULL_CNT);

    // R7: a write never lands on a full FIFO
    a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.count != FULL_CNT));
    // R9: a read of an empty FIFO leaves it empty
    a_r9_empty_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st_q.count == '0 && !wr_en) |=> (st_q.count == '0));
    // R2: occupancy stays within depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);
endmodule

// File: rtl/irrx_frame_ctl.sv
module irrx_frame_ctl
    import irrx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             sym_err,
    input  logic             frame_end,
    input  logic             crc_ok,
    input  logic             stat_rd,
    input  logic             fifo_full,
    input  logic [LEN_W-1:0] limit,
    output logic             wr_en,
    output logic             wr_eof,
    output logic             retag_en,
    output rx_flags_t        flags
);
    typedef struct packed {
        logic [LEN_W:0] cnt;
        logic           cut;
        logic           stored;
        rx_flags_t      fl;
    } ctl_st_t;

    ctl_st_t        st_d, st_q;
    logic [LEN_W:0] cnt_inc;

    assign cnt_inc = st_q.cnt + 1'b1;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        wr_eof   = 1'b0;
        retag_en = 1'b0;
        if (stat_rd) st_d.fl = '0;
        if (sym_err) begin
            st_d.fl.phy = 1'b1;
            retag_en    = st_q.stored;
            st_d.cnt    = '0;
            st_d.cut    = 1'b0;
            st_d.stored = 1'b0;
        end else begin
            if (rx_valid && !st_q.cut) begin
                if (cnt_inc > {1'b0, limit}) begin
                    st_d.fl.len = 1'b1;
                    st_d.cut    = 1'b1;
                    retag_en    = st_q.stored;
                    st_d.stored = 1'b0;
                end else if (fifo_full) begin
                    st_d.fl.ovr = 1'b1;
                end else begin
                    wr_en       = 1'b1;
                    wr_eof      = frame_end;
                    st_d.stored = 1'b1;
                end
                st_d.cnt = cnt_inc;
            end
            if (frame_end) begin
                if (!wr_en) retag_en = st_q.stored;
                if (!crc_ok) st_d.fl.crc = 1'b1;
                st_d.cnt    = '0;
                st_d.cut    = 1'b0;
                st_d.stored = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.fl;

    // R5: the symbol-error flag rises only after a reported symbol error
    a_r5_phy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fl.phy) |-> $past(sym_err));
    // R5: no byte is stored in a symbol-error cycle
    a_r5_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err |-> !wr_en);
    // R4: a cut frame stores nothing until its end
    a_r4_cut_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cut |-> !wr_en);
    // R8: a status read without a new symbol error clears the flag
    a_r8_clear_phy: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !sym_err) |=> !st_q.fl.phy);
    // R6: a bad CRC at frame end is always recorded
    a_r6_crc_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !crc_ok && !sym_err) |=> st_q.fl.crc);
endmodule

// File: rtl/irrx_frame_fifo.sv
module irrx_frame_fifo
    import irrx_pkg::*;
#(
    parameter int          DEPTH   = 32,
    parameter int          LEN_W   = 16,
    parameter logic [15:0] LIM_RST = 16'd2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lim_lo_we,
    input  logic       lim_hi_we,
    input  logic [7:0] lim_wdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       sym_err,
    input  logic       frame_end,
    input  logic       crc_ok,
    input  logic       host_rd,
    input  logic       stat_rd,
    output logic [7:0] rd_data,
    output logic [7:0] status
);
    logic [LEN_W-1:0] limit;
    logic             wr_en, wr_eof, retag_en, nonempty, full;
    rx_entry_t        head, wr_entry;
    rx_flags_t        flags;

    irrx_limit_reg #(.LEN_W(LEN_W), .LIM_RST(LIM_RST)) u_limit (
        .clk(clk), .rst_n(rst_n), .lo_we(lim_lo_we), .hi_we(lim_hi_we),
        .wdata(lim_wdata), .limit(limit)
    );

    irrx_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .sym_err(sym_err),
        .frame_end(frame_end), .crc_ok(crc_ok), .stat_rd(stat_rd),
        .fifo_full(full), .limit(limit), .wr_en(wr_en), .wr_eof(wr_eof),
        .retag_en(retag_en), .flags(flags)
    );

    assign wr_entry.eof  = wr_eof;
    assign wr_entry.data = rx_byte;

    irrx_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
        .rd_en(host_rd), .retag_en(retag_en), .head(head),
        .nonempty(nonempty), .full(full)
    );

    always_comb begin
        status          = '0;
        status[ST_DRDY] = nonempty;
        status[ST_OVR]  = flags.ovr;
        status[ST_CRC]  = flags.crc;
        status[ST_PHY]  = flags.phy;
        status[ST_LEN]  = flags.len;
        status[ST_LAST] = nonempty && head.eof;
    end

    assign rd_data = head.data;

    // R1: reserved status bits stay clear
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00);
    // R3: the last-byte flag never shows on an empty FIFO
    a_r3_last_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_LAST] |-> status[ST_DRDY]);
endmodule

// File: tb/irrx_frame_fifo_test.sv
`timescale 1ns/1ps
module irrx_frame_fifo_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lim_lo_we = 0, lim_hi_we = 0;
    logic [7:0] lim_wdata = 0;
    logic rx_valid = 0, sym_err = 0, frame_end = 0, crc_ok = 1, host_rd = 0, stat_rd = 0;
    logic [7:0] rx_byte = 0;
    logic [7:0] rd_data, status;

    int compared = 0, mismatched = 0;

    // reference state
    int mq[$];
    bit m_len, m_phy, m_crc, m_ovr, m_cut, m_stored;
    int m_cnt, m_max;

    always #4 clk = ~clk;

    irrx_frame_fifo uut (
        .clk(clk), .rst_n(rst_n), .lim_lo_we(lim_lo_we), .lim_hi_we(lim_hi_we),
        .lim_wdata(lim_wdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .sym_err(sym_err), .frame_end(frame_end), .crc_ok(crc_ok),
        .host_rd(host_rd), .stat_rd(stat_rd), .rd_data(rd_data), .status(status)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step();
        bit wrote, retag;
        int nxt;
        wrote = 0; retag = 0;
        if (stat_rd) begin m_len = 0; m_phy = 0; m_crc = 0; m_ovr = 0; end
        if (sym_err) begin
            m_phy = 1; retag = m_stored; m_cnt = 0; m_cut = 0; m_stored = 0;
        end else begin
            if (rx_valid && !m_cut) begin
                nxt = m_cnt + 1;
                if (nxt > m_max) begin
                    m_len = 1; m_cut = 1; retag = m_stored; m_stored = 0;
                end else if (mq.size() == 32) begin
                    m_ovr = 1;
                end else begin
                    wrote = 1; m_stored = 1;
                end
                m_cnt = nxt;
            end
            if (frame_end) begin
                if (!wrote) retag = m_stored;
                if (!crc_ok) m_crc = 1;
                m_cnt = 0; m_cut = 0; m_stored = 0;
            end
        end
        if (retag && mq.size() > 0) mq[mq.size()-1] = mq[mq.size()-1] | 256;
        if (host_rd && mq.size() > 0) void'(mq.pop_front());
        if (wrote) mq.push_back({23'd0, frame_end, rx_byte});
        if (lim_lo_we) m_max = (m_max & 32'hFF00) | lim_wdata;
        if (lim_hi_we) m_max = (m_max & 32'h00FF) | (int'(lim_wdata) << 8);
    endtask

    task automatic cmp_all();
        bit ne;
        ne = (mq.size() > 0);
        chk("R2 data-ready", status[0], ne);
        chk("R3 last-byte", status[7], ne ? mq[0][8] : 1'b0);
        chk("R4 length flag", status[4], m_len);
        chk("R5 symbol flag", status[3], m_phy);
        chk("R6 crc flag", status[2], m_crc);
        chk("R7 overrun flag", status[1], m_ovr);
        chk("R1 reserved bits", status[6:5], 2'b00);
        if (ne) chk("R2 head byte", rd_data, mq[0][7:0]);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp_all();
        lim_lo_we = 0; lim_hi_we = 0; rx_valid = 0; sym_err = 0;
        frame_end = 0; crc_ok = 1; host_rd = 0; stat_rd = 0;
    endtask

    task automatic put(input logic [7:0] b);
        rx_valid = 1; rx_byte = b; cyc();
    endtask
    task automatic endf(input bit ok);
        frame_end = 1; crc_ok = ok; cyc();
    endtask
    task automatic pop();
        host_rd = 1; cyc();
    endtask
    task automatic sread();
        stat_rd = 1; cyc();
    endtask
    task automatic setmax(input logic [15:0] v);
        lim_lo_we = 1; lim_wdata = v[7:0]; cyc();
        lim_hi_we = 1; lim_wdata = v[15:8]; cyc();
    endtask
    task automatic drain();
        while (mq.size() > 0) pop();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        m_max = 2048;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status, 8'h00);
        rst_n = 1;
        @(negedge clk);
        chk("R1 status after reset", status, 8'h00);
        cmp_all();

        // R2/R3: plain frame, tag on separate frame_end
        setmax(16'd5);
        put(8'h11); put(8'h22); put(8'h33); endf(1);
        chk("R2 first byte waiting", status, 8'h01);
        pop(); pop();
        chk("R3 last byte at head", status, 8'h81);
        pop();

        // R3/R6: byte with frame_end in one cycle, bad CRC
        put(8'h44); rx_valid = 1; rx_byte = 8'h55; frame_end = 1; crc_ok = 0; cyc();
        pop();
        chk("R3 same-cycle tag and R6 crc", status, 8'h85);
        sread();
        chk("R8 flags cleared", status, 8'h81);
        pop();

        // R4: length cut, further bytes dropped
        for (int i = 0; i < 8; i++) put(8'hA0 + 8'(i));
        endf(1);
        chk("R4 five bytes kept and flag", status, 8'h11);
        drain();
        sread();

        // R5: symbol error mid-frame, with a byte in the same cycle
        put(8'h61); put(8'h62);
        rx_valid = 1; rx_byte = 8'h63; sym_err = 1; frame_end = 1; cyc();
        pop();
        chk("R5 abort tag, byte dropped", status, 8'h89);
        pop();
        chk("R5 nothing else stored", status, 8'h08);

        // R10: empty frames add nothing
        endf(1);
        sym_err = 1; cyc();
        chk("R10 no entry from empty frame", status, 8'h08);

        // R9: read on empty
        pop();
        chk("R9 empty read idle", status, 8'h08);
        put(8'h70); endf(1);
        chk("R9 next byte intact", rd_data, 8'h70);
        drain();

        // R8: set and clear in the same cycle
        stat_rd = 1; sym_err = 1; cyc();
        chk("R8 set beats clear", status[3], 1'b1);
        sread();

        // R7: overrun
        setmax(16'd300);
        for (int i = 0; i < 35; i++) put(8'(i));
        endf(1);
        chk("R7 overrun on full", status, 8'h03);
        pop(); put(8'hEE); endf(1);
        drain();
        sread();

        // R4: high limit byte, concurrent reads
        setmax(16'h0100);
        for (int i = 0; i < 270; i++) begin
            rx_valid = 1; rx_byte = 8'(i * 7); host_rd = 1; cyc();
        end
        endf(1);
        chk("R4 limit 256 flag", status[4], 1'b1);
        drain();
        sread();

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            rx_valid  = ($urandom_range(0, 99) < 55);
            rx_byte   = 8'($urandom_range(0, 255));
            sym_err   = ($urandom_range(0, 99) < 2);
            frame_end = ($urandom_range(0, 99) < 7);
            crc_ok    = ($urandom_range(0, 99) < 70);
            host_rd   = ($urandom_range(0, 99) < 40);
            stat_rd   = ($urandom_range(0, 99) < 5);
            if ($urandom_range(0, 99) < 2) begin
                lim_lo_we = 1; lim_hi_we = 1;
                lim_wdata = 8'($urandom_range(0, 40));
            end
            cyc();
        end
        drain();
        finish_run();
    end
endmodule